// File: doc/BRIEF.md
# Bidirectional Energy Accumulator With Overflow Flags

This block keeps running energy totals for a metering datapath. Once per measurement cycle an upstream stage offers one item on a valid/ready stream: a signed real-energy result for that cycle, plus the raw RMS voltage and the raw RMS current. A positive real result is added to a delivered-energy total. A negative real result has its magnitude added to a separate returned-energy total. The product of the two RMS values is the apparent energy. It is never negative, so it feeds a single apparent-energy total.

Each total is a free-running register that wraps modulo 2^ACC_W. When an addition carries out of a total, a sticky bit for that total is set in a small overflow status vector. Supervisory software reads the totals. It counts the wraps and then clears the bits it has accounted for by pulsing the matching lines of a write-one-to-clear input.

The stream has no back-pressure. `in_ready` is low only while reset is asserted and for the first edge after reset is released. From then on it stays high, so every cycle with `in_valid` high transfers one item. The item is accepted at a rising edge where `in_valid && in_ready` holds. Its effect on the totals and on the flags is visible after the next rising edge.

Top module: `energy_totalizer`

## Requirements
- R1: `in_ready` rises after reset and then stays high. An item is taken only at an edge with `in_valid` and `in_ready` both high. Data offered with `in_valid` low leaves every total unchanged.
- R2: After reset, all three totals are zero, `ovf_flags` is 3'b000, and `in_ready` is low while `rst_n` is low.
- R3: A positive real-energy value is added to `del_total`. It leaves `ret_total` unchanged.
- R4: A negative real-energy value adds its two's-complement magnitude to `ret_total` and leaves `del_total` unchanged. This includes the most negative value, whose magnitude is 2^(E_W-1).
- R5: A real-energy value of zero changes neither `del_total` nor `ret_total`.
- R6: Every accepted item adds `in_v_rms * in_i_rms` (unsigned, 2*RMS_W bits) to `app_total`.
- R7: Each total wraps modulo 2^ACC_W. A carry out of a total sets its flag, using these bit positions: bit 0 for delivered, bit 1 for returned, bit 2 for apparent. No flag rises in a cycle with no update.
- R8: A set overflow flag stays set until the host clears it.
- R9: A 1 on bit n of `ovf_clr` during one cycle clears `ovf_flags[n]` at that edge. Bits written 0 are not affected.
- R10: If a carry and a clear hit the same flag at the same edge, the flag ends up set.
- R11: An item accepted at edge k is reflected in the totals and flags after edge k+1. Back-to-back items, one per cycle, are all accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Item offered on the input stream |
| in_ready | output | 1 | Block can take an item; high after reset |
| in_energy | input | E_W (48) | Signed real energy for the cycle |
| in_v_rms | input | RMS_W (24) | Raw RMS voltage, unsigned |
| in_i_rms | input | RMS_W (24) | Raw RMS current, unsigned |
| ovf_clr | input | 3 | Write-one-to-clear strobes for the overflow flags |
| del_total | output | ACC_W (48) | Delivered-energy total |
| ret_total | output | ACC_W (48) | Returned-energy total |
| app_total | output | ACC_W (48) | Apparent-energy total |
| ovf_flags | output | 3 | Sticky overflow flags {apparent, returned, delivered} |

## Verification
The totals are driven with isolated positive, negative and zero real values. These show that the sign split steers each value to only one total, and that zero steers it to neither. The most negative input checks that the magnitude is not truncated by one bit. A back-to-back burst of mixed signs confirms one-per-cycle accumulation at the stated latency. Near-full-scale items then force a wrap on each total in turn, which separates carry detection per flag bit. Partial clear masks, idle stretches and a clear timed onto the same edge as a wrap tell apart write-one-to-clear, stickiness and set priority.

// File: rtl/energy_pkg.sv
package energy_pkg;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned CH_DEL = 0;
  localparam int unsigned CH_RET = 1;
  localparam int unsigned CH_APP = 2;
endpackage

// File: rtl/energy_front.sv
// Stage one: sign split, magnitude and V*I product, registered on acceptance.
module energy_front #(
  parameter int unsigned E_W   = 48,
  parameter int unsigned RMS_W = 24,
  parameter int unsigned ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [E_W-1:0]   energy,
  input  logic [RMS_W-1:0] v_rms,
  input  logic [RMS_W-1:0] i_rms,
  output logic             s_valid,
  output logic [ACC_W-1:0] del_inc,
  output logic [ACC_W-1:0] ret_inc,
  output logic [ACC_W-1:0] app_inc
);
  localparam int unsigned PROD_W = 2 * RMS_W;

  logic [E_W-1:0]    mag;
  logic [PROD_W-1:0] prod;
  logic              is_neg;

  assign is_neg = energy[E_W-1];
  assign mag    = ~energy + E_W'(1);
  assign prod   = PROD_W'(v_rms) * PROD_W'(i_rms);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      del_inc <= '0;
      ret_inc <= '0;
      app_inc <= '0;
    end else begin
      s_valid <= take;
      if (take) begin
        del_inc <= is_neg ? '0 : ACC_W'(energy);
        ret_inc <= is_neg ? ACC_W'(mag) : '0;
        app_inc <= ACC_W'(prod);
      end
    end
  end
endmodule

// File: rtl/wrap_acc.sv
// One wrapping total; carry is combinational so the flag lands on the same edge.
module wrap_acc #(
  parameter int unsigned ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] total,
  output logic             carry
);
  logic [ACC_W:0] sum;

  assign sum   = {1'b0, total} + {1'b0, inc};
  assign carry = en & sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  total <= '0;
    else if (en) total <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/sticky_flags.sv
// Set-priority sticky bits with write-one-to-clear.
module sticky_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[b] <= 1'b0;
      else if (set[b]) flags[b] <= 1'b1;
      else if (clr[b]) flags[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/energy_totalizer.sv
module energy_totalizer
  import energy_pkg::*;
#(
  parameter int unsigned E_W   = 48,
  parameter int unsigned RMS_W = 24,
  parameter int unsigned ACC_W = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [E_W-1:0]      in_energy,
  input  logic [RMS_W-1:0]    in_v_rms,
  input  logic [RMS_W-1:0]    in_i_rms,
  input  logic [N_CH-1:0]     ovf_clr,
  output logic [ACC_W-1:0]    del_total,
  output logic [ACC_W-1:0]    ret_total,
  output logic [ACC_W-1:0]    app_total,
  output logic [N_CH-1:0]     ovf_flags
);
  logic             take;
  logic             stage_valid;
  logic [ACC_W-1:0] incs   [N_CH];
  logic [ACC_W-1:0] totals [N_CH];
  logic [N_CH-1:0]  carries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign take = in_valid & in_ready;

  energy_front #(.E_W(E_W), .RMS_W(RMS_W), .ACC_W(ACC_W)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .energy  (in_energy),
    .v_rms   (in_v_rms),
    .i_rms   (in_i_rms),
    .s_valid (stage_valid),
    .del_inc (incs[CH_DEL]),
    .ret_inc (incs[CH_RET]),
    .app_inc (incs[CH_APP])
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_acc
    wrap_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stage_valid),
      .inc   (incs[c]),
      .total (totals[c]),
      .carry (carries[c])
    );
  end

  sticky_flags #(.N(N_CH)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (carries),
    .clr   (ovf_clr),
    .flags (ovf_flags)
  );

  assign del_total = totals[CH_DEL];
  assign ret_total = totals[CH_RET];
  assign app_total = totals[CH_APP];
endmodule

// File: rtl/energy_totalizer_chk.sv
module energy_totalizer_chk #(
  parameter int unsigned ACC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             stage_valid,
  input logic [2:0]       ovf_clr,
  input logic [ACC_W-1:0] del_total,
  input logic [ACC_W-1:0] ret_total,
  input logic [ACC_W-1:0] app_total,
  input logic [2:0]       ovf_flags
);
  assert_ready_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  assert_sign_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(del_total) |-> $stable(ret_total));

  assert_app_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid |=> (app_total >= $past(app_total)) || ovf_flags[2]);

  assert_no_set_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid |=> ((ovf_flags & ~$past(ovf_flags)) == 3'b000));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ovf_flags) & ~$past(ovf_clr)) & ~ovf_flags) == 3'b000));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_clr != 3'b000) && !stage_valid) |=> ((ovf_flags & $past(ovf_clr)) == 3'b000));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid |=> ($stable(del_total) && $stable(ret_total) && $stable(app_total)));
endmodule

bind energy_totalizer energy_totalizer_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .stage_valid (stage_valid),
  .ovf_clr     (ovf_clr),
  .del_total   (del_total),
  .ret_total   (ret_total),
  .app_total   (app_total),
  .ovf_flags   (ovf_flags)
);

// File: tb/sim_energy_totalizer.sv
`timescale 1ns/1ps
module sim_energy_totalizer;
  localparam int W = 48;
  localparam int RW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_energy = '0;
  logic [RW-1:0] in_v_rms = '0;
  logic [RW-1:0] in_i_rms = '0;
  logic [2:0]    ovf_clr = '0;
  logic [W-1:0]  del_total, ret_total, app_total;
  logic [2:0]    ovf_flags;

  always #4 clk = ~clk;

  energy_totalizer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_energy(in_energy), .in_v_rms(in_v_rms), .in_i_rms(in_i_rms),
    .ovf_clr(ovf_clr), .del_total(del_total), .ret_total(ret_total),
    .app_total(app_total), .ovf_flags(ovf_flags)
  );

  typedef struct {
    logic [W-1:0] del;
    logic [W-1:0] ret;
    logic [W-1:0] app;
    logic [2:0]   flg;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_del = '0, m_ret = '0, m_app = '0;
  logic [2:0]   m_flg = '0;
  logic p1 = 1'b0, p2 = 1'b0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: offers one item and pushes the expected state it produces
  task automatic send(input logic [W-1:0] e, input logic [RW-1:0] v,
                      input logic [RW-1:0] i, input string tag);
    logic [W:0]   s;
    logic [W-1:0] mag;
    logic [2*RW-1:0] p;
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_energy = e; in_v_rms = v; in_i_rms = i;
    if (e[W-1]) begin
      mag = ~e + 1'b1;
      s = {1'b0, m_ret} + {1'b0, mag};
      m_ret = s[W-1:0];
      if (s[W]) m_flg[1] = 1'b1;
    end else begin
      s = {1'b0, m_del} + {1'b0, e};
      m_del = s[W-1:0];
      if (s[W]) m_flg[0] = 1'b1;
    end
    p = {{RW{1'b0}}, v} * {{RW{1'b0}}, i};
    s = {1'b0, m_app} + {1'b0, p};
    m_app = s[W-1:0];
    if (s[W]) m_flg[2] = 1'b1;
    it.del = m_del; it.ret = m_ret; it.app = m_app; it.flg = m_flg; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(input logic [2:0] m, input string tag);
    @(negedge clk);
    ovf_clr = m;
    m_flg = m_flg & ~m;
    @(negedge clk);
    ovf_clr = 3'b000;
    check(tag, W'(ovf_flags), W'(m_flg));
  endtask

  // monitor: pops one expected item per visible update
  always @(posedge clk) begin
    p1 <= in_valid && in_ready;
    p2 <= p1;
  end

  always @(negedge clk) begin
    if (p2) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: unexpected update actual=%h expected=none", del_total);
      end else begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " del"}, del_total, it.del);
        check({it.tag, " ret"}, ret_total, it.ret);
        check({it.tag, " app"}, app_total, it.app);
        check({it.tag, " flags"}, W'(ovf_flags), W'(it.flg));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 ready in reset", W'(in_ready), W'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 del reset", del_total, '0);
    check("R2 ret reset", ret_total, '0);
    check("R2 app reset", app_total, '0);
    check("R2 flags reset", W'(ovf_flags), '0);
    check("R1 ready after reset", W'(in_ready), W'(1));

    send(W'(1000), 24'd3, 24'd5, "R3 positive");
    idle(3);
    send(-W'(700), 24'd0, 24'd9, "R4 negative");
    idle(3);
    send('0, 24'd2, 24'd2, "R5 zero");
    idle(3);
    send({1'b1, {(W-1){1'b0}}}, 24'd1, 24'd1, "R4 most negative");
    idle(3);

    // R11 back-to-back burst of mixed signs
    send(W'(12345), 24'd100, 24'd200, "R11 burst0");
    send(-W'(55), 24'd7, 24'd0, "R11 burst1");
    send('0, 24'hABCDEF, 24'h123456, "R11 burst2");
    send(W'(1), 24'd1, 24'd1, "R11 burst3");
    idle(4);
    check("R11 queue drained", W'(q.size()), '0);

    // R1 data without valid is ignored
    @(negedge clk);
    in_valid = 1'b0; in_energy = W'(999); in_v_rms = 24'd50; in_i_rms = 24'd50;
    repeat (4) @(negedge clk);
    check("R1 del hold", del_total, m_del);
    check("R1 ret hold", ret_total, m_ret);
    check("R1 app hold", app_total, m_app);

    // R6/R7 apparent wrap
    send('0, 24'hFFFFFF, 24'hFFFFFF, "R6 app large");
    send('0, 24'hFFFFFF, 24'hFFFFFF, "R7 app wrap");
    idle(3);
    check("R7 app flag bit2", W'(ovf_flags), W'(3'b100));

    idle(6);
    check("R8 flag sticky", W'(ovf_flags), W'(3'b100));

    clear(3'b011, "R9 zero bits untouched");
    clear(3'b100, "R9 clear bit2");

    // R7 returned wrap, then delivered wrap
    send({1'b1, {(W-1){1'b0}}}, 24'd0, 24'd0, "R7 ret wrap");
    idle(3);
    send({1'b0, {(W-1){1'b1}}}, 24'd0, 24'd0, "R7 del big");
    send({1'b0, {(W-1){1'b1}}}, 24'd0, 24'd0, "R7 del wrap");
    idle(3);
    check("R7 ret and del flags", W'(ovf_flags), W'(3'b011));

    // R10 carry and clear of bit2 on the same edge
    clear(3'b011, "R9 clear low bits");
    send('0, 24'hFFFFFF, 24'hFFFFFF, "R10 wrap prep");
    idle(3);
    if (ovf_flags[2]) begin
      clear(3'b100, "R10 prep clear");
    end
    send('0, 24'hFFFFFF, 24'hFFFFFF, "R10 set vs clear");
    @(negedge clk);
    in_valid = 1'b0;
    ovf_clr = 3'b100;
    @(negedge clk);
    ovf_clr = 3'b000;
    repeat (3) @(negedge clk);
    check("R10 set wins", W'(ovf_flags[2]), W'(1));

    repeat (4) @(negedge clk);
    check("R11 all consumed", W'(q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule